// File: doc/BRIEF.md
# Interpolating Upconverter Chain with NCO Mixer

This block sits between a low-rate complex baseband source and a high-rate converter datapath. It takes I/Q sample pairs at the interface rate and raises the rate through up to four cascaded interpolate-by-two stages. Each enabled stage puts a zero between consecutive samples and removes the resulting image with a fixed half-band filter. The filter doubles the gain, so the zeros cost no amplitude. A numerically controlled oscillator and a complex mixer then move the carrier from DC to a programmed frequency. The block emits the real part of the mixed signal, one sample per clock.

Each stage has its own enable. A disabled stage passes samples through unchanged, so the overall interpolation factor is two raised to the number of enabled stages. A single enable picks zero-IF operation: the mixer is bypassed and the filtered in-phase stream goes to the output with the carrier left at DC. The block paces the source with a ready strobe. It never stalls: on a ready cycle with no valid sample, it takes a zero.

Top module: `duc_interp_chain`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_sample` is 0 and `in_ready` is 1.
- R2: With E stages enabled, `in_ready` is high exactly once every 2^E cycles, starting on the first cycle after reset. With E = 0 it is high on every cycle.
- R3: A sample is taken only on a cycle with `in_ready` high. On such a cycle a low `in_valid` inserts a zero sample. Data presented while `in_ready` is low has no effect on the output.
- R4: For each input x[n], an enabled stage emits x[n-2] and then (-x[n] + 9*x[n-1] + 9*x[n-2] - x[n-3] + 8) >>> 4, where >>> is an arithmetic (floor) shift. The filter history starts at zero after reset.
- R5: The computed (odd) output of a stage saturates to the range -32768 to 32767.
- R6: A constant input c reaches the output as exactly c once the chain has settled, for any stage configuration.
- R7: Any subset of stages may be enabled. A disabled stage adds neither rate change nor filtering, so the response depends only on the number of enabled stages.
- R8: With `cfg_mix_en` low, `out_sample` equals the chain's in-phase output one cycle later, and the quadrature input has no effect.
- R9: A 32-bit phase accumulator is 0 on the first cycle after reset and adds `cfg_freq` every cycle, so output k (k = 0 on the first cycle) uses phase `cfg_freq*k`. Its top 6 bits select one of 64 points per turn of a sine table with amplitude 32767. Cosine uses the index plus 16.
- R10: With `cfg_mix_en` high, `out_sample` = (I*cos - Q*sin + 16384) >>> 15, saturated to 16 bits, where I and Q are the chain outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stage_en | input | 4 | Per-stage interpolation enable, bit 0 nearest the input; static outside reset |
| cfg_mix_en | input | 1 | 1 = mix to the programmed frequency, 0 = zero-IF bypass |
| cfg_freq | input | 32 | Phase increment per output cycle |
| in_valid | input | 1 | Source has a sample on the data inputs |
| in_ready | output | 1 | Block takes a sample at this clock edge |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| out_sample | output | 16 | Real output sample at the full rate, signed |

## Verification
If a stage's delay line or phase alternation goes wrong, the output stream departs from the reference half-band sequence. The error shows within two output periods of that stage, spread through every later stage by the interpolation factor. A corrupted rate counter shows immediately on `in_ready`, because the strobe spacing no longer matches 2^E. A fault in the accumulator or table folding shows on the mixed output within a few cycles, since every quadrant is visited with a quarter-turn increment. The sign or rounding of the I and Q products is checked against the same sequences.

// File: rtl/duc_pkg.sv
// Shared widths and sample type for the interpolating upconverter.
// Assumes signed two's-complement samples throughout.
package duc_pkg;
    localparam int SAMP_W   = 16;
    localparam int PHASE_W  = 32;
    localparam int STAGES   = 4;
    typedef logic signed [SAMP_W-1:0] samp_t;
endpackage

// File: rtl/duc_rate_ctrl.sv
// Rate controller: free-running counter that produces, for every stage,
// the strobe on which it takes an input and the strobe on which it emits
// an output. Assumes the enables are static outside reset.
module duc_rate_ctrl #(
    parameter int N_STAGES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] stage_en,
    output logic [N_STAGES-1:0] stb_in,
    output logic [N_STAGES-1:0] stb_out,
    output logic                ready
);
    localparam int MW = N_STAGES + 1;

    logic [N_STAGES-1:0] cnt;
    logic [MW-1:0]       cnt_x;

    assign cnt_x = {1'b0, cnt};

    // mask with the lowest 'bits' bits set
    function automatic logic [MW-1:0] low_mask(input int bits);
        logic [MW-1:0] m;
        m = '0;
        for (int b = 0; b < MW; b++) begin
            if (b < bits) m[b] = 1'b1;
        end
        return m;
    endfunction

    // free-running high-rate cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // walk from the output end; each enabled stage halves the upstream rate
    always_comb begin
        int down;
        down    = 0;
        stb_in  = '0;
        stb_out = '0;
        for (int s = N_STAGES - 1; s >= 0; s--) begin
            stb_out[s] = ((cnt_x & low_mask(down)) == '0);
            if (stage_en[s]) begin
                stb_in[s] = ((cnt_x & low_mask(down + 1)) == '0);
                down      = down + 1;
            end else begin
                stb_in[s] = stb_out[s];
            end
        end
        ready = ((cnt_x & low_mask(down)) == '0);
    end
endmodule

// File: rtl/duc_hb_stage.sv
// One interpolate-by-2 lane: zero insertion folded into a polyphase
// half-band filter with gain 2. Taps (-1,0,9,16,9,0,-1)/16, so the even
// phase is a pure delay and the odd phase is a 4-tap sum.
// Assumes stb_in only occurs together with stb_out when enabled.
module duc_hb_stage #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                stb_in,
    input  logic                stb_out,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    localparam int AW     = W + 5;
    localparam int RND_SH = 4;
    localparam logic signed [AW-1:0] RND_OFS = AW'(1 << (RND_SH - 1));
    localparam logic signed [AW-1:0] MAXV    = AW'((1 << (W - 1)) - 1);
    localparam logic signed [AW-1:0] MINV    = -MAXV - AW'(1);

    logic signed [W-1:0]  tap [4];
    logic signed [W-1:0]  held;
    logic signed [AW-1:0] near_sum, far_sum, acc, shifted;
    logic signed [W-1:0]  mid;

    // odd-phase filter: 9*(inner pair) - (outer pair), rounded and clamped
    always_comb begin
        near_sum = AW'(tap[1]) + AW'(tap[2]);
        far_sum  = AW'(tap[0]) + AW'(tap[3]);
        acc      = (near_sum <<< 3) + near_sum - far_sum + RND_OFS;
        shifted  = acc >>> RND_SH;
        if (shifted > MAXV)      mid = MAXV[W-1:0];
        else if (shifted < MINV) mid = MINV[W-1:0];
        else                     mid = shifted[W-1:0];
    end

    // delay line and output register, advanced on the stage strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 4; t++) tap[t] <= '0;
            held <= '0;
        end else if (en && stb_out) begin
            if (stb_in) begin
                tap[0] <= din;
                tap[1] <= tap[0];
                tap[2] <= tap[1];
                tap[3] <= tap[2];
                held   <= tap[1];
            end else begin
                held   <= mid;
            end
        end
    end

    // a disabled stage is a wire at its input rate
    assign dout = en ? held : din;
endmodule

// File: rtl/duc_nco_mixer.sv
// NCO and real-output complex mixer. A phase accumulator indexes a
// 64-point sine built from a 17-entry quarter-wave table (Q1.15). Output
// is I*cos - Q*sin, rounded and saturated; bypass forwards I unchanged.
module duc_nco_mixer #(
    parameter int W    = 16,
    parameter int PH_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mix_en,
    input  logic [PH_W-1:0]     freq,
    input  logic signed [W-1:0] din_i,
    input  logic signed [W-1:0] din_q,
    output logic signed [W-1:0] dout
);
    localparam int TRIG_W = 16;
    localparam int LUT_A  = 6;
    localparam int QA     = LUT_A - 2;
    localparam int PW     = W + TRIG_W + 1;
    localparam logic [LUT_A-1:0]  QUARTER = LUT_A'(1 << QA);
    localparam logic signed [PW-1:0] RND  = PW'(1 << (TRIG_W - 2));
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic [PH_W-1:0]          phase;
    logic [LUT_A-1:0]         idx_s, idx_c;
    logic signed [TRIG_W-1:0] sin_v, cos_v;
    logic signed [PW-1:0]     prod_i, prod_q, diff, scaled;
    logic signed [W-1:0]      mixed;

    // quarter-wave magnitudes, 32767*sin(k*pi/32)
    function automatic logic signed [TRIG_W-1:0] quarter(input logic [QA:0] k);
        case (k)
            5'd0:  return 16'sd0;
            5'd1:  return 16'sd3212;
            5'd2:  return 16'sd6393;
            5'd3:  return 16'sd9512;
            5'd4:  return 16'sd12539;
            5'd5:  return 16'sd15446;
            5'd6:  return 16'sd18204;
            5'd7:  return 16'sd20787;
            5'd8:  return 16'sd23170;
            5'd9:  return 16'sd25329;
            5'd10: return 16'sd27245;
            5'd11: return 16'sd28898;
            5'd12: return 16'sd30273;
            5'd13: return 16'sd31356;
            5'd14: return 16'sd32137;
            5'd15: return 16'sd32609;
            default: return 16'sd32767;
        endcase
    endfunction

    // fold a full-turn index onto the quarter table
    function automatic logic signed [TRIG_W-1:0] sine_at(input logic [LUT_A-1:0] idx);
        logic [QA:0]              k;
        logic signed [TRIG_W-1:0] mag;
        k   = {1'b0, idx[QA-1:0]};
        mag = idx[QA] ? quarter(QUARTER[QA:0] - k) : quarter(k);
        return idx[QA+1] ? -mag : mag;
    endfunction

    // table lookup and mixing arithmetic
    always_comb begin
        idx_s  = phase[PH_W-1 -: LUT_A];
        idx_c  = idx_s + QUARTER;
        sin_v  = sine_at(idx_s);
        cos_v  = sine_at(idx_c);
        prod_i = PW'(din_i) * PW'(cos_v);
        prod_q = PW'(din_q) * PW'(sin_v);
        diff   = prod_i - prod_q + RND;
        scaled = diff >>> (TRIG_W - 1);
        if (scaled > MAXV)      mixed = MAXV[W-1:0];
        else if (scaled < MINV) mixed = MINV[W-1:0];
        else                    mixed = scaled[W-1:0];
    end

    // phase accumulator and registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            dout  <= '0;
        end else begin
            phase <= phase + freq;
            dout  <= mix_en ? mixed : din_i;
        end
    end
endmodule

// File: rtl/duc_interp_chain.sv
// Top: input pacing, a cascade of N_STAGES two-lane half-band
// interpolators and the NCO mixer. Assumes cfg_stage_en changes only
// under reset; one output sample per clock.
module duc_interp_chain
    import duc_pkg::*;
#(
    parameter int N_STAGES = STAGES,
    parameter int W        = SAMP_W,
    parameter int PH_W     = PHASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] cfg_stage_en,
    input  logic                cfg_mix_en,
    input  logic [PH_W-1:0]     cfg_freq,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic signed [W-1:0] out_sample
);
    logic [N_STAGES-1:0] stb_in, stb_out;
    logic signed [W-1:0] lane_i [N_STAGES+1];
    logic signed [W-1:0] lane_q [N_STAGES+1];
    logic signed [W-1:0] mix_i, mix_q;

    duc_rate_ctrl #(.N_STAGES(N_STAGES)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_en (cfg_stage_en),
        .stb_in   (stb_in),
        .stb_out  (stb_out),
        .ready    (in_ready)
    );

    // a missing sample on a ready cycle becomes a zero
    assign lane_i[0] = in_valid ? in_i : '0;
    assign lane_q[0] = in_valid ? in_q : '0;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        duc_hb_stage #(.W(W)) u_hb_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (cfg_stage_en[s]),
            .stb_in  (stb_in[s]),
            .stb_out (stb_out[s]),
            .din     (lane_i[s]),
            .dout    (lane_i[s+1])
        );
        duc_hb_stage #(.W(W)) u_hb_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (cfg_stage_en[s]),
            .stb_in  (stb_in[s]),
            .stb_out (stb_out[s]),
            .din     (lane_q[s]),
            .dout    (lane_q[s+1])
        );
    end

    assign mix_i = lane_i[N_STAGES];
    assign mix_q = lane_q[N_STAGES];

    duc_nco_mixer #(.W(W), .PH_W(PH_W)) u_mix (
        .clk    (clk),
        .rst_n  (rst_n),
        .mix_en (cfg_mix_en),
        .freq   (cfg_freq),
        .din_i  (mix_i),
        .din_q  (mix_q),
        .dout   (out_sample)
    );
endmodule

// File: rtl/duc_interp_chk.sv
// Checker bound to the top: pacing of in_ready, bypass path and the
// zero-in/zero-out property of the mixer.
module duc_interp_chk #(
    parameter int N_STAGES = 4,
    parameter int W        = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_STAGES-1:0] cfg_stage_en,
    input logic                cfg_mix_en,
    input logic                in_ready,
    input logic signed [W-1:0] mix_i,
    input logic signed [W-1:0] mix_q,
    input logic signed [W-1:0] out_sample
);
    logic [7:0] gap;
    logic       seen;

    // cycles since the last ready strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (in_ready) begin
            gap  <= 8'd1;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 8'd1;
        end
    end

    // R1
    first_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> in_ready);

    // R2
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && in_ready) |-> (gap == (8'd1 << $countones(cfg_stage_en))));

    // R2
    ready_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && (cfg_stage_en != '0)) |=> !in_ready);

    // R8
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mix_en |=> (out_sample == $past(mix_i)));

    // R10
    zero_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_i == '0 && mix_q == '0) |=> (out_sample == '0));
endmodule

bind duc_interp_chain duc_interp_chk #(.N_STAGES(N_STAGES), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_stage_en (cfg_stage_en),
    .cfg_mix_en   (cfg_mix_en),
    .in_ready     (in_ready),
    .mix_i        (mix_i),
    .mix_q        (mix_q),
    .out_sample   (out_sample)
);

// File: tb/tb_duc_interp_chain.sv
// Scoreboard bench: a driver task builds the expected stream from a
// behavioural half-band model and queues it; a monitor pops and compares.
module tb_duc_interp_chain;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         cfg_stage_en = 4'b0;
    logic               cfg_mix_en = 1'b0;
    logic [31:0]        cfg_freq = 32'd0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic signed [15:0] out_sample;

    int checks = 0, errors = 0;
    int exp_q[$];
    int mq[$];
    bit sb_on = 0, aligned = 0, sat_seen = 0, done = 0;
    longint edges = 0;

    duc_interp_chain dut (
        .clk(clk), .rst_n(rst_n), .cfg_stage_en(cfg_stage_en),
        .cfg_mix_en(cfg_mix_en), .cfg_freq(cfg_freq), .in_valid(in_valid),
        .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .out_sample(out_sample)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    function automatic int clamp16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    task automatic check(input string req, input longint act, input longint expv, input int tol);
        checks++;
        if (act > expv + tol || act < expv - tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one interpolate-by-2 stage of the reference, applied to mq
    function automatic void hb_model();
        int r[$];
        int x0 = 0, x1 = 0, x2 = 0, x3 = 0;
        for (int n = 0; n < mq.size(); n++) begin
            x3 = x2; x2 = x1; x1 = x0; x0 = mq[n];
            r.push_back(x2);
            r.push_back(clamp16((-x0 + 9 * x1 + 9 * x2 - x3 + 8) >>> 4));
        end
        mq = r;
    endfunction

    function automatic int sin_tab(input int idx);
        real a;
        a = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(idx % 64) / 64.0);
        return int'(a);
    endfunction

    function automatic int mix_model(input int ci, input int cq, input longint k, input logic [31:0] f);
        logic [63:0] full;
        int idx, s, c;
        full = 64'(f) * 64'(k);
        idx  = int'(full[31:26]);
        s    = sin_tab(idx);
        c    = sin_tab(idx + 16);
        return clamp16((longint'(ci) * c - longint'(cq) * s + 16384) >>> 15);
    endfunction

    task automatic do_reset(input logic [3:0] en, input logic men, input logic [31:0] f);
        @(negedge clk);
        rst_n = 1'b0; cfg_stage_en = en; cfg_mix_en = men; cfg_freq = f;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: align on first nonzero output, then compare queue entries
    always @(negedge clk) begin
        if (sb_on && rst_n) begin
            if (!aligned && out_sample != 0) aligned = 1;
            if (aligned && exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                if (e == 32767 || e == -32768) begin
                    sat_seen = 1;
                    check("R5 saturated stage output", out_sample, e, 0);
                end else begin
                    check("R4 interpolated stream", out_sample, e, 0);
                end
            end
        end
    end

    // driver: queue model output, then feed samples on ready cycles only
    task automatic run_stream(input logic [3:0] en, input string tag);
        int vals[24] = '{1000, -2000, 15000, -32768, 32767, 32767, -32768, 500,
                         0, 7000, -7000, 123, -4567, 32000, 31000, -30000,
                         2222, -1, 1, 9000, -9000, 4000, 300, -3000};
        bit gap[24];
        int idx, ne;
        foreach (gap[g]) gap[g] = (g == 8);
        mq.delete();
        foreach (vals[v]) mq.push_back(gap[v] ? 0 : vals[v]);
        repeat (8) mq.push_back(0);
        ne = $countones(en);
        for (int st = 0; st < ne; st++) hb_model();
        while (mq.size() > 0 && mq[0] == 0) void'(mq.pop_front());
        exp_q = mq;
        do_reset(en, 1'b0, 32'h1234_5678);
        aligned = 0; sb_on = 1;
        idx = 0;
        while (idx < 24) begin
            if (in_ready) begin
                in_valid = !gap[idx];
                in_i = gap[idx] ? 16'sh5A5A : 16'(vals[idx]);
                in_q = 16'(-vals[idx]);
                idx++;
            end else begin
                // R3: garbage with valid high while not ready
                in_valid = 1'b1;
                in_i = 16'($urandom);
                in_q = 16'($urandom);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int w = 0; w < 3000 && exp_q.size() > 0; w++) @(negedge clk);
        check({tag, " R3 stream fully matched"}, exp_q.size(), 0, 0);
        check({tag, " R7 output aligned"}, aligned, 1, 0);
        sb_on = 0;
    endtask

    task automatic cadence(input logic [3:0] en, input int period);
        int cnt;
        do_reset(en, 1'b0, 32'd0);
        #1;
        check("R1 ready first cycle", in_ready, 1, 0);
        cnt = 0;
        for (int c = 0; c < 64; c++) begin
            if (in_ready) cnt++;
            @(negedge clk);
        end
        check("R2 ready count in 64 cycles", cnt, 64 / period, 0);
    endtask

    task automatic const_run(input logic [3:0] en, input logic men, input logic [31:0] f,
                             input int ci, input int cq, input string req);
        do_reset(en, men, f);
        in_i = 16'(ci); in_q = 16'(cq); in_valid = 1'b1;
        repeat (300) @(negedge clk);
        for (int j = 0; j < 8; j++) begin
            if (men) check(req, out_sample, mix_model(ci, cq, edges - 1, f), 2);
            else     check(req, out_sample, ci, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(4'b1111, 1'b1, 32'h4000_0000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 output in reset", out_sample, 0, 0);
        check("R1 ready in reset", in_ready, 1, 0);
        // R2 / R7: cadence for several configurations
        cadence(4'b1111, 16);
        cadence(4'b0101, 4);
        cadence(4'b0000, 1);
        // R4 R5 R7 R3: streams through different stage subsets
        run_stream(4'b0001, "one stage");
        run_stream(4'b1111, "four stages");
        run_stream(4'b1010, "two sparse stages");
        run_stream(4'b0000, "no stages");
        check("R5 saturation reached", sat_seen, 1, 0);
        // R6 R8: DC unity gain in bypass with a large Q ignored
        const_run(4'b1111, 1'b0, 32'd0, -12345, 30000, "R6 R8 DC through bypass");
        const_run(4'b0110, 1'b0, 32'd0, 7777, -32768, "R6 R8 DC two stages");
        // R9 R10: quarter-turn steps, odd step, and saturation
        const_run(4'b0011, 1'b1, 32'h4000_0000, 1000, 3000, "R9 R10 quarter turn");
        const_run(4'b1000, 1'b1, 32'h0A3D_70A4, -20000, 11000, "R9 R10 fine step");
        const_run(4'b0000, 1'b1, 32'h2000_0000, 32767, -32767, "R10 saturation");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule